// File: doc/BRIEF.md
# Debug Run Control Register

This block is a 32-bit control register, read and written like a CSR, that holds two groups of execution parameters for a hart under debug. The lower half sets how the hart behaves once it resumes normal execution. The upper half sets how it behaves while it runs program-buffer code in debug mode. The hart's state machine lies outside the block. It reports each state change on one of four single-cycle strobe inputs.

On the strobes the register updates itself. On entry to debug-halted from normal execution it records the current privilege and clears the debug-mode parameters. On entry from program-buffer execution it records only the privilege. From an internal record of the current execution mode and from its fields, it drives the control outputs. Some are levels that hold while the hart runs: single-step, interrupt, trigger, trace and counter enables, PC freeze, gating of privilege-changing instructions, and the commit policy on redirection. Others are qualifiers that are valid only in the cycle of a resume strobe: the privilege to load, the exception-commit request and the wait-for-interrupt request.

Top module: `dbg_runctl_reg`

## Requirements
- R1: After reset every field reads 0 and the execution mode is normal run: interrupts, triggers, trace and counters are enabled, and step, PC freeze and privileged-instruction trap are off.
- R2: A write stores bits 9:0 and 28:16. Bits 15:10 and 31:29 always read 0 and ignore writes. The read data is combinational from the register.
- R3: On `ent_from_run` the normal privilege field (bits 1:0) and the debug privilege field (bits 17:16) both load `cur_prv`, bits 28:18 clear, and bits 9:2 keep their values. The mode becomes debug-halted.
- R4: On `ent_from_drun` only bits 17:16 change, loading `cur_prv`. The mode becomes debug-halted.
- R5: When a write and an entry strobe fall in the same cycle, the fields that the strobe captures or clears take the hardware value and all other writable bits take the written value.
- R6: In the cycle of `rsm_run`, `prv_ld` is 1 and `prv_ld_val` equals bits 1:0. `exc_commit` equals bit 6 and `wfi_req` equals bit 7. The mode becomes normal run.
- R7: In the cycle of `rsm_drun`, `prv_ld` is 1 and `prv_ld_val` equals bits 17:16. `exc_commit` equals bit 22 and `wfi_req` equals bit 23. The mode becomes program-buffer run.
- R8: `step_en` follows bit 2 in normal run, bit 18 in program-buffer run, and is 0 when debug-halted.
- R9: `irq_en` is the inverse of bit 3 in normal run and follows bit 19 in program-buffer run. `trig_en` is the inverse of bit 8 or follows bit 24. `trace_en` is the inverse of bit 9 or follows bit 25. All three are 0 when debug-halted.
- R10: `pc_freeze` is 1 exactly in program-buffer run with bit 26 clear. `priv_insn_trap` is 1 exactly in program-buffer run with bit 27 clear.
- R11: `cnt_en` is 1 in normal run, follows bit 28 in program-buffer run, and is 0 when debug-halted.
- R12: `exc_redir_commit` is the inverse of bit 4 in normal run and follows bit 20 in program-buffer run. `brk_redir_commit` follows bit 5 or bit 21 respectively. Both are 0 when debug-halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, shared with the debug logic |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Current register value |
| cur_prv | input | 2 | Privilege the hart holds now |
| ent_from_run | input | 1 | Strobe: normal run or WFI-halted to debug-halted |
| ent_from_drun | input | 1 | Strobe: program-buffer run to debug-halted |
| rsm_run | input | 1 | Strobe: debug-halted to normal run |
| rsm_drun | input | 1 | Strobe: debug-halted to program-buffer run |
| prv_ld | output | 1 | Load a new privilege this cycle |
| prv_ld_val | output | 2 | Privilege to load |
| exc_commit | output | 1 | Commit saved exception data on this resume |
| wfi_req | output | 1 | Enter wait-for-interrupt on this resume |
| step_en | output | 1 | Single-step active |
| irq_en | output | 1 | Interrupts allowed |
| trig_en | output | 1 | Trigger logic allowed |
| trace_en | output | 1 | Trace allowed |
| cnt_en | output | 1 | Hart-local counters may count |
| pc_freeze | output | 1 | Hold the program counter |
| priv_insn_trap | output | 1 | Treat privilege-changing instructions as illegal |
| exc_redir_commit | output | 1 | Commit non-breakpoint exceptions on redirection |
| brk_redir_commit | output | 1 | Commit breakpoint exceptions on redirection |

## Verification
The assertions assume that at most one of the four transition strobes is high in any cycle and that each strobe lasts one cycle, since the external state machine makes one transition at a time. They also assume that a `cur_prv` value is meaningful only when an entry strobe is high. The bench drives each strobe alone for exactly one clock. It asserts a write together with an entry strobe only in the collision scenario, which is allowed. It changes `cur_prv` only between strobes.

// File: rtl/dbg_runctl_reg.sv
module dbg_runctl_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic [1:0]  cur_prv,
  input  logic        ent_from_run,
  input  logic        ent_from_drun,
  input  logic        rsm_run,
  input  logic        rsm_drun,
  output logic        prv_ld,
  output logic [1:0]  prv_ld_val,
  output logic        exc_commit,
  output logic        wfi_req,
  output logic        step_en,
  output logic        irq_en,
  output logic        trig_en,
  output logic        trace_en,
  output logic        cnt_en,
  output logic        pc_freeze,
  output logic        priv_insn_trap,
  output logic        exc_redir_commit,
  output logic        brk_redir_commit
);
  localparam logic [31:0] WMASK = 32'h1FFF_03FF;
  localparam int DLO = 18;
  localparam int DHI = 28;

  localparam logic [1:0] MD_RUN   = 2'd0;
  localparam logic [1:0] MD_DHALT = 2'd1;
  localparam logic [1:0] MD_DRUN  = 2'd2;

  logic [31:0] q, nxt;
  logic [1:0]  mode;
  logic        in_run, in_drun;

  always_comb begin
    nxt = q;
    if (csr_we) nxt = csr_wdata & WMASK;
    if (ent_from_run) begin
      nxt[1:0]     = cur_prv;
      nxt[17:16]   = cur_prv;
      nxt[DHI:DLO] = '0;
    end
    if (ent_from_drun) nxt[17:16] = cur_prv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          mode <= MD_RUN;
    else if (ent_from_run || ent_from_drun) mode <= MD_DHALT;
    else if (rsm_run)                    mode <= MD_RUN;
    else if (rsm_drun)                   mode <= MD_DRUN;
  end

  assign in_run  = (mode == MD_RUN);
  assign in_drun = (mode == MD_DRUN);

  assign csr_rdata  = q;
  assign prv_ld     = rsm_run | rsm_drun;
  assign prv_ld_val = rsm_drun ? q[17:16] : q[1:0];
  assign exc_commit = (rsm_run & q[6]) | (rsm_drun & q[22]);
  assign wfi_req    = (rsm_run & q[7]) | (rsm_drun & q[23]);

  assign step_en          = (in_run & q[2])  | (in_drun & q[18]);
  assign irq_en           = (in_run & ~q[3]) | (in_drun & q[19]);
  assign exc_redir_commit = (in_run & ~q[4]) | (in_drun & q[20]);
  assign brk_redir_commit = (in_run & q[5])  | (in_drun & q[21]);
  assign trig_en          = (in_run & ~q[8]) | (in_drun & q[24]);
  assign trace_en         = (in_run & ~q[9]) | (in_drun & q[25]);
  assign pc_freeze        = in_drun & ~q[26];
  assign priv_insn_trap   = in_drun & ~q[27];
  assign cnt_en           = in_run | (in_drun & q[28]);

  // R3 R4 R6 R7 (strobe exclusivity assumed by the capture logic)
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ent_from_run, ent_from_drun, rsm_run, rsm_drun}));

  // R2
  resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata & ~WMASK) == 32'h0);

  // R3
  entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_from_run |=> csr_rdata[DHI:DLO] == '0);

  // R3
  entry_prv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_from_run |=> (csr_rdata[1:0] == $past(cur_prv)) && (csr_rdata[17:16] == $past(cur_prv)));

  // R4
  drun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_from_drun && !csr_we) |=> ($stable(csr_rdata[15:0]) && $stable(csr_rdata[31:18])));

  // R6
  resume_prv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsm_run |-> (prv_ld && prv_ld_val == csr_rdata[1:0]));

  // R10
  freeze_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_freeze |-> (!csr_rdata[26] && !step_en || !csr_rdata[26]));

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_from_run || ent_from_drun) |=> !(step_en || irq_en || cnt_en || pc_freeze));
endmodule

// File: tb/dbg_runctl_reg_bench.sv
module dbg_runctl_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic [1:0]  cur_prv = 2'd0;
  logic        ent_from_run = 1'b0, ent_from_drun = 1'b0, rsm_run = 1'b0, rsm_drun = 1'b0;
  logic        prv_ld, exc_commit, wfi_req, step_en, irq_en, trig_en, trace_en, cnt_en;
  logic        pc_freeze, priv_insn_trap, exc_redir_commit, brk_redir_commit;
  logic [1:0]  prv_ld_val;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  dbg_runctl_reg u_dbg_runctl_reg (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .cur_prv(cur_prv), .ent_from_run(ent_from_run), .ent_from_drun(ent_from_drun),
    .rsm_run(rsm_run), .rsm_drun(rsm_drun), .prv_ld(prv_ld), .prv_ld_val(prv_ld_val),
    .exc_commit(exc_commit), .wfi_req(wfi_req), .step_en(step_en), .irq_en(irq_en),
    .trig_en(trig_en), .trace_en(trace_en), .cnt_en(cnt_en), .pc_freeze(pc_freeze),
    .priv_insn_trap(priv_insn_trap), .exc_redir_commit(exc_redir_commit),
    .brk_redir_commit(brk_redir_commit));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [31:0] wd, input logic er, input logic ed,
                       input logic rr, input logic rd, input logic [1:0] p);
    @(negedge clk);
    csr_we = we; csr_wdata = wd; ent_from_run = er; ent_from_drun = ed;
    rsm_run = rr; rsm_drun = rd; cur_prv = p;
    #1;
  endtask

  task automatic tick;
    @(posedge clk); #1;
    csr_we = 1'b0; ent_from_run = 1'b0; ent_from_drun = 1'b0; rsm_run = 1'b0; rsm_drun = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    chk("R1 rdata", csr_rdata, 32'h0);
    chk("R1 irq_en", irq_en, 1);
    chk("R1 trig_trace", {trig_en, trace_en}, 2'b11);
    chk("R1 step_freeze_trap", {step_en, pc_freeze, priv_insn_trap}, 3'b000);
    chk("R11 cnt_en run", cnt_en, 1);
  endtask

  task automatic t_write;
    drive(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0); tick;
    chk("R2 mask", csr_rdata, 32'h1FFF_03FF);
    chk("R8 step run", step_en, 1);
    chk("R9 irq/trig/trace run", {irq_en, trig_en, trace_en}, 3'b000);
    chk("R12 redir commit run", {exc_redir_commit, brk_redir_commit}, 2'b01);
  endtask

  task automatic t_enter_run;
    drive(0, 0, 1, 0, 0, 0, 2'd1); tick;
    chk("R3 capture", csr_rdata, 32'h0001_03FD);
    chk("R8 halted step", step_en, 0);
    chk("R9 halted irq", irq_en, 0);
    chk("R11 halted cnt", cnt_en, 0);
  endtask

  task automatic t_resume_run;
    drive(0, 0, 0, 0, 1, 0, 0);
    chk("R6 prv_ld", {prv_ld, prv_ld_val}, 3'b101);
    chk("R6 commit_wfi", {exc_commit, wfi_req}, 2'b11);
    tick;
    chk("R6 run after resume", {step_en, cnt_en, prv_ld}, 3'b110);
  endtask

  task automatic t_drun;
    drive(0, 0, 1, 0, 0, 0, 2'd3); tick;
    drive(1, 32'h1FFE_0000, 0, 0, 0, 0, 0); tick;
    chk("R2 debug write", csr_rdata, 32'h1FFE_0000);
    drive(0, 0, 0, 0, 0, 1, 0);
    chk("R7 prv_ld", {prv_ld, prv_ld_val}, 3'b110);
    chk("R7 commit_wfi", {exc_commit, wfi_req}, 2'b11);
    tick;
    chk("R8 drun step", step_en, 1);
    chk("R9 drun irq/trig/trace", {irq_en, trig_en, trace_en}, 3'b111);
    chk("R10 drun enabled", {pc_freeze, priv_insn_trap}, 2'b00);
    chk("R11 drun cnt", cnt_en, 1);
    chk("R12 drun redir", {exc_redir_commit, brk_redir_commit}, 2'b11);
    drive(1, 32'h0002_0000, 0, 0, 0, 0, 0); tick;
    chk("R10 drun gated", {pc_freeze, priv_insn_trap}, 2'b11);
    chk("R11 drun cnt off", cnt_en, 0);
    chk("R8 drun step off", {step_en, irq_en}, 2'b00);
    drive(1, 32'h1FFE_0000, 0, 0, 0, 0, 0); tick;
    drive(0, 0, 0, 1, 0, 0, 2'd0); tick;
    chk("R4 drun exit", csr_rdata, 32'h1FFC_0000);
    chk("R4 halted", {step_en, pc_freeze}, 2'b00);
  endtask

  task automatic t_collide;
    drive(1, 32'hFFFF_FFFF, 1, 0, 0, 0, 2'd2); tick;
    chk("R5 write+entry", csr_rdata, 32'h0002_03FE);
    drive(1, 32'h1FFF_03FF, 0, 1, 0, 0, 2'd1); tick;
    chk("R5 write+drun exit", csr_rdata, 32'h1FFD_03FF);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    t_reset;
    t_write;
    t_enter_run;
    t_resume_run;
    t_drun;
    t_collide;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule